// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable model of a clocked static RAM with a built-in
burst address generator. On every rising clock edge it samples an address, a
data word, a write strobe, two chip selects, two independent active-low
burst-start strobes and an active-low step input. One start strobe comes from
a processor and always forces a read. The other comes from a cache controller
and obeys the write strobe. A start edge loads the address. Each later edge
with no start strobe is another access at the internally kept burst address.
If the step input is low on that edge, the two low address bits advance first,
modulo 4, and the upper bits stay fixed.

A write completes at the edge that samples it, so no write pulse has to be
generated outside the block. Read data is registered and appears after the
sampling edge. The shared data bus is split into separate in and out ports and
a drive-enable port. The drive enable follows an asynchronous output-enable
input, but only after a read edge. Address width and word width are
parameters. The default is 2048 words of 9 bits. Setting `ADDR_W` to 15 gives
32768 words.

Top module: `bsram_core`

## Requirements
- R1: While `rst` is high, and after it is released until the next selected start edge, `dq_oe_o` is 0. Edges without a start strobe read and write nothing.
- R2: An edge where `cpu_go_n_i` or `cc_go_n_i` is 0, `en_n_i` is 0 and `en_i` is 1 is a selected start edge. It accesses the word at `addr_i` and opens a burst based on that address.
- R3: An edge where a start strobe is 0 but `en_n_i` is 1 or `en_i` is 0 accesses nothing and closes any open burst. Later edges without a start strobe then access nothing.
- R4: On an edge inside an open burst with no start strobe, `step_n_i` = 0 first advances bits [1:0] of the burst address by one modulo 4 (3 wraps to 0), keeping the upper bits. `step_n_i` = 1 repeats the same address.
- R5: A selected start edge with `wr_n_i` = 0 and `cpu_go_n_i` = 1 writes `din_i`. A burst edge with `wr_n_i` = 0 also writes `din_i`. The write completes at that edge, and `dq_oe_o` is 0 in the following cycle.
- R6: A selected start edge with `cpu_go_n_i` = 0 is a read whatever `wr_n_i` is, and leaves the memory unchanged.
- R7: After a read edge, `dout_o` holds the addressed word until the next read edge. `dq_oe_o` equals NOT `oe_n_i` combinationally during that cycle. After a write or idle edge, `dq_oe_o` is 0.
- R8: `addr_i` is ignored on every edge that is not a selected start edge.
- R9: A start through `cc_go_n_i` with `wr_n_i` = 0 is a write, so a burst of writes can be driven from the cache-controller strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address, used on selected start edges |
| din_i | input | DATA_W | Write data |
| wr_n_i | input | 1 | Write strobe, active low |
| en_n_i | input | 1 | Chip select, active low |
| en_i | input | 1 | Chip select, active high |
| cpu_go_n_i | input | 1 | Processor burst start, active low, forces read |
| cc_go_n_i | input | 1 | Cache-controller burst start, active low |
| step_n_i | input | 1 | Burst step, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dout_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Drive enable for the shared data bus |

## Verification
Every access takes effect at the edge that samples it. A write updates the memory at that edge. A read moves the word into `dout_o` at that edge, so the result is visible for the whole following cycle. The bench drives inputs on the falling edge and lets its behavioural model step on the rising edge. It compares `dq_oe_o` and `dout_o` on the next falling edge, exactly one edge after the stimulus. The asynchronous path from `oe_n_i` is checked a nanosecond after `oe_n_i` changes, within the same cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int LSB_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        logic strobe;    // either start strobe asserted
        logic selected;  // both chip selects true
        logic forced_rd; // processor strobe asserted
    } start_t;

    function automatic logic [LSB_W-1:0] step_lsb(input logic [LSB_W-1:0] cur,
                                                  input logic adv);
        return adv ? cur + 1'b1 : cur;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_n_i,
    input  logic              en_n_i,
    input  logic              en_i,
    input  logic              cpu_go_n_i,
    input  logic              cc_go_n_i,
    input  logic              step_n_i,
    output acc_e              kind_o,
    output logic [ADDR_W-1:0] acc_addr_o
);
    localparam int HI_W = ADDR_W - LSB_W;

    logic              open_q;
    logic [HI_W-1:0]   base_q;
    logic [LSB_W-1:0]  lsb_q;
    logic [LSB_W-1:0]  lsb_nx;
    start_t            st;

    always_comb begin
        st.strobe    = ~cpu_go_n_i | ~cc_go_n_i;
        st.selected  = ~en_n_i & en_i;
        st.forced_rd = ~cpu_go_n_i;
        lsb_nx       = step_lsb(lsb_q, ~step_n_i);
        kind_o       = ACC_NONE;
        acc_addr_o   = {base_q, lsb_nx};
        if (st.strobe) begin
            if (st.selected) begin
                acc_addr_o = addr_i;
                kind_o     = (~wr_n_i & ~st.forced_rd) ? ACC_WRITE : ACC_READ;
            end
        end else if (open_q) begin
            kind_o = ~wr_n_i ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            base_q <= '0;
            lsb_q  <= '0;
        end else if (st.strobe) begin
            open_q <= st.selected;
            if (st.selected) begin
                base_q <= addr_i[ADDR_W-1:LSB_W];
                lsb_q  <= addr_i[LSB_W-1:0];
            end
        end else if (open_q) begin
            lsb_q <= lsb_nx;
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (kind_i == ACC_WRITE) begin
            mem[addr_i] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= (kind_i == ACC_READ);
            if (kind_i == ACC_READ) begin
                rdata_o <= mem[addr_i];
            end
        end
    end
endmodule

// File: rtl/bsram_drive.sv
module bsram_drive #(
    parameter int DATA_W = 9
) (
    input  logic              rvalid_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dq_oe_o
);
    assign dout_o  = rdata_i;
    assign dq_oe_o = rvalid_i & ~oe_n_i;
endmodule

// File: rtl/bsram_core.sv
module bsram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              wr_n_i,
    input  logic              en_n_i,
    input  logic              en_i,
    input  logic              cpu_go_n_i,
    input  logic              cc_go_n_i,
    input  logic              step_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dq_oe_o
);
    acc_e              kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .wr_n_i     (wr_n_i),
        .en_n_i     (en_n_i),
        .en_i       (en_i),
        .cpu_go_n_i (cpu_go_n_i),
        .cc_go_n_i  (cc_go_n_i),
        .step_n_i   (step_n_i),
        .kind_o     (kind),
        .acc_addr_o (acc_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .kind_i   (kind),
        .addr_i   (acc_addr),
        .din_i    (din_i),
        .rdata_o  (rdata),
        .rvalid_o (rvalid)
    );

    bsram_drive #(.DATA_W(DATA_W)) u_drive (
        .rvalid_i (rvalid),
        .oe_n_i   (oe_n_i),
        .rdata_i  (rdata),
        .dout_o   (dout_o),
        .dq_oe_o  (dq_oe_o)
    );
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] din_i,
    input logic              wr_n_i,
    input logic              en_n_i,
    input logic              en_i,
    input logic              cpu_go_n_i,
    input logic              cc_go_n_i,
    input logic              step_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dq_oe_o
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_oe_o); // R1

    AST_DESEL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        ((!cpu_go_n_i || !cc_go_n_i) && (en_n_i || !en_i)) |=> !dq_oe_o); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_i && cpu_go_n_i) |=> !dq_oe_o); // R5

    AST_CPU_FORCES_READ: assert property (@(posedge clk) disable iff (rst)
        (!cpu_go_n_i && !en_n_i && en_i && !oe_n_i) |=> (dq_oe_o || oe_n_i)); // R6

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        dq_oe_o |-> !oe_n_i); // R7

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_i && cpu_go_n_i) |=> $stable(dout_o)); // R7
endmodule

bind bsram_core bsram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bsram_core.sv
module test_bsram_core;
    localparam int AW    = 11;
    localparam int DW    = 9;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr_n = 1'b1, en_n = 1'b0, en = 1'b1;
    logic          cpu_n = 1'b1, cc_n = 1'b1, step_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dq_oe;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    logic [DW-1:0] ref_mem [WORDS];
    bit            m_open = 0;
    int            m_base = 0, m_lsb = 0;
    bit            m_vld = 0;
    logic [DW-1:0] m_q = '0;

    always #5 clk = ~clk;

    bsram_core #(.ADDR_W(AW), .DATA_W(DW)) i_bsram_core (
        .clk(clk), .rst(rst), .addr_i(addr), .din_i(din), .wr_n_i(wr_n),
        .en_n_i(en_n), .en_i(en), .cpu_go_n_i(cpu_n), .cc_go_n_i(cc_n),
        .step_n_i(step_n), .oe_n_i(oe_n), .dout_o(dout), .dq_oe_o(dq_oe)
    );

    always @(posedge clk) begin
        int  where;
        int  op; // 0 none, 1 read, 2 write
        op = 0;
        where = 0;
        if (rst) begin
            m_open = 0;
            m_vld  = 0;
        end else begin
            if (!cpu_n || !cc_n) begin
                if (!en_n && en) begin
                    where  = int'(addr);
                    m_base = where / 4;
                    m_lsb  = where % 4;
                    m_open = 1;
                    op = (!wr_n && cpu_n) ? 2 : 1;
                end else begin
                    m_open = 0;
                end
            end else if (m_open) begin
                if (!step_n) m_lsb = (m_lsb + 1) % 4;
                where = m_base * 4 + m_lsb;
                op = wr_n ? 1 : 2;
            end
            if (op == 2) ref_mem[where] = din;
            m_vld = (op == 1);
            if (op == 1) m_q = ref_mem[where];
        end
    end

    task automatic compare_now();
        logic exp_oe;
        exp_oe = m_vld && !oe_n;
        compared++;
        if (dq_oe !== exp_oe) begin
            mismatched++;
            $display("FAIL %s: dq_oe_o=%b expected %b at %0t", tag, dq_oe, exp_oe, $time);
        end
        if (m_vld) begin
            compared++;
            if (dout !== m_q) begin
                mismatched++;
                $display("FAIL %s: dout_o=%h expected %h at %0t", tag, dout, m_q, $time);
            end
        end
    endtask

    task automatic cyc(input logic c_cpu, input logic c_cc, input logic c_wr,
                       input logic c_step, input int c_addr, input int c_din);
        cpu_n  = c_cpu;
        cc_n   = c_cc;
        wr_n   = c_wr;
        step_n = c_step;
        addr   = AW'(c_addr);
        din    = DW'(c_din);
        @(posedge clk);
        @(negedge clk);
        compare_now();
    endtask

    function automatic int pattern(input int a);
        return (a * 37 + 11) % 512;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then edges with no start do nothing
        tag = "R1";
        repeat (2) begin @(posedge clk); @(negedge clk); compare_now(); end
        rst = 1'b0;
        for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 5, 0);

        // R9 / R5 / R4: fill memory with write bursts on the cache-controller strobe
        tag = "R9";
        for (int b = 0; b < WORDS / 4; b++) begin
            cyc(1, 0, 0, 1, b * 4, pattern(b * 4));
            for (int k = 1; k < 4; k++) cyc(1, 1, 0, 0, 0, pattern(b * 4 + k));
        end

        // R2 / R4: read burst from lsb 2 wraps 2,3,0,1
        tag = "R4";
        cyc(0, 1, 1, 1, 'h0A6, 0);
        for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 0, 0);
        // R4: stalls repeat the address
        cyc(1, 1, 1, 1, 0, 0);
        cyc(1, 1, 1, 1, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);

        // R2: start through the cache-controller strobe as a read
        tag = "R2";
        cyc(1, 0, 1, 1, 'h3FF, 0);
        cyc(1, 1, 1, 0, 0, 0);

        // R6: processor strobe with write low reads, memory keeps old word
        tag = "R6";
        cyc(0, 1, 0, 1, 'h010, 'h155);
        cyc(1, 1, 1, 1, 0, 0);

        // R5: write inside a burst, then read it back
        tag = "R5";
        cyc(0, 1, 1, 1, 'h021, 0);
        cyc(1, 1, 0, 0, 0, 'h0AA);
        cyc(1, 1, 1, 1, 0, 0);
        cyc(0, 1, 1, 1, 'h022, 0);

        // R3: deselected strobes: no write, burst closed
        tag = "R3";
        en_n = 1'b1;
        cyc(1, 0, 0, 1, 'h030, 'h1FF);
        en_n = 1'b0;
        cyc(1, 1, 0, 0, 0, 'h077);
        cyc(1, 1, 1, 0, 0, 0);
        en = 1'b0;
        cyc(0, 1, 1, 1, 'h031, 0);
        en = 1'b1;
        cyc(1, 1, 1, 1, 0, 0);
        cyc(0, 1, 1, 1, 'h030, 0);
        cyc(1, 1, 1, 0, 0, 0);

        // R8: address input ignored inside a burst
        tag = "R8";
        cyc(0, 1, 1, 1, 'h043, 0);
        cyc(1, 1, 1, 0, 'h7FF, 0);
        cyc(1, 1, 1, 0, 'h123, 0);
        cyc(1, 1, 0, 1, 'h500, 'h0C3);
        cyc(0, 1, 1, 1, 'h041, 0);
        cyc(0, 1, 1, 1, 'h500, 0);

        // R7: asynchronous output enable
        tag = "R7";
        oe_n = 1'b1;
        cyc(0, 1, 1, 1, 'h044, 0);
        oe_n = 1'b0; #1 compare_now();
        oe_n = 1'b1; #1 compare_now();
        oe_n = 1'b0;
        cyc(1, 1, 0, 1, 0, 'h0E1);
        cyc(1, 1, 1, 1, 0, 0);

        // R1: reset in mid-burst closes it
        tag = "R1";
        cyc(0, 1, 1, 1, 'h060, 0);
        rst = 1'b1;
        cyc(1, 1, 1, 1, 0, 0);
        rst = 1'b0;
        cyc(1, 1, 0, 1, 0, 'h0BB);
        cyc(1, 1, 1, 0, 0, 0);
        cyc(0, 1, 1, 1, 'h060, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule